// File: doc/BRIEF.md
# Dual-Edge Gated Storage Cell

This block reproduces, on a single fast system clock, the behaviour of an old two-sided storage cell. The cell holds one bit. A set side and a clear side each have a gate level and a trigger line. A side acts only when its own trigger line shows a rising edge while its gate is high. When only one side sees an edge, the other side's gate has no effect. When both sides fire in the same cycle, the bit toggles. Two level-sensitive force lines override everything else while they are held. The clear force wins when both force lines are active.

A mode input selects between edge operation and agreement operation. In agreement operation the bit follows two data inputs only when they agree, and it holds while they differ. This absorbs skew between the two inputs. Trigger lines are asynchronous to the system clock. Each one passes through a synchronizer and a rising-edge detector before it can act.

The core is a two-state machine. Its states are `ST_CLEAR` (bit 0) and `ST_SET` (bit 1). The transitions are:
- SET_EDGE: `ST_CLEAR` to `ST_SET`.
- CLEAR_EDGE: `ST_SET` to `ST_CLEAR`.
- TOGGLE: either state to the other.
- AGREE_HI: to `ST_SET`.
- AGREE_LO: to `ST_CLEAR`.
- FORCE_HI: to `ST_SET`.
- FORCE_LO: to `ST_CLEAR`.
- RESET: to `ST_CLEAR`.
- HOLD: self-loop.

Top module: `trig_cell`

## Requirements
- R1: In edge mode (`mode_agree`=0), with no force active, a set-side rising edge with `set_gate`=1 and no qualified clear-side edge drives `q` to 1 (SET_EDGE).
- R2: In edge mode, a clear-side rising edge with `clr_gate`=1 and no qualified set-side edge drives `q` to 0 (CLEAR_EDGE). A gate held high while its trigger shows no rising edge has no effect.
- R3: A side acts only on its own rising edge. A side that sees no edge is disregarded whatever its gate level. An edge whose gate is 0 does nothing. A falling trigger never acts.
- R4: In edge mode, qualified rising edges on both sides in the same cycle invert `q` (TOGGLE).
- R5: While `force_set`=1 and `force_clr`=0, `q` is 1 in the same cycle, overriding edges and mode. The stored bit is loaded as well, so the value remains after release (FORCE_HI). `force_clr`=1 likewise gives 0 (FORCE_LO).
- R6: With `force_set` and `force_clr` both 1, `q` is 0.
- R7: With `mode_agree`=1, `q` becomes 1 when `agree_a`=`agree_b`=1 and 0 when both are 0, and holds while they differ. Trigger edges are ignored in this mode. With `mode_agree`=0, `agree_a` and `agree_b` have no effect.
- R8: Suppose a trigger is sampled low at clock edge k-1 and high at clock edge k. Its side then acts at clock edge k+2, with its gate sampled at that same edge, and `q` is unchanged before it.
- R9: Synchronous `rst`=1 clears the stored bit (`q`=0 when no force is active) and the edge history to 0. A trigger that is held high through reset is therefore seen as a rising edge after release.
- R10: `q_n` is always the inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_agree | input | 1 | 0 = edge operation, 1 = agreement operation |
| set_trig | input | 1 | Set-side trigger line (asynchronous) |
| set_gate | input | 1 | Set-side gate level |
| clr_trig | input | 1 | Clear-side trigger line (asynchronous) |
| clr_gate | input | 1 | Clear-side gate level |
| agree_a | input | 1 | First agreement data input |
| agree_b | input | 1 | Second agreement data input |
| force_set | input | 1 | Level force to 1 |
| force_clr | input | 1 | Level force to 0, dominant |
| q | output | 1 | Stored bit |
| q_n | output | 1 | Inverse of the stored bit |

## Verification
The in-line properties check the following on every cycle:
- the next state after each qualified single-side edge, toggle, agreement match or force;
- that the state is stable when no side is qualified;
- that a detected edge lasts exactly one cycle.

Other behaviours show only in the bench's scenarios:
- the two-cycle trigger latency measured at the ports;
- the combinational override of `q` by the force lines;
- a trigger held high through reset being seen as a new edge;
- the `agree_a` and `agree_b` inputs being ignored in edge mode.

The bench sweeps every combination of initial state, the two edges and the two gates, and every agreement pattern and force pattern.

// File: rtl/trig_cell_pkg.sv
`timescale 1ns/1ps
package trig_cell_pkg;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_SET   = 1'b1
    } cell_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SET    = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_TOGGLE = 2'd3
    } cell_act_e;

    localparam int SIDE_SET = 0;
    localparam int SIDE_CLR = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/trig_edge_detect.sv
`timescale 1ns/1ps
module trig_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic rise
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    // pipe[SYNC_STAGES-1] is the synchronized sample, pipe[SYNC_STAGES] the previous one
    logic [PIPE_W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[PIPE_W-2:0], trig};
        end
    end

    assign rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

    // A detected edge lasts a single cycle (R8)
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/trig_action_decode.sv
`timescale 1ns/1ps
module trig_action_decode
    import trig_cell_pkg::*;
(
    input  logic                 mode_agree,
    input  logic [NUM_SIDES-1:0] side_rise,
    input  logic [NUM_SIDES-1:0] side_gate,
    input  logic                 agree_a,
    input  logic                 agree_b,
    output cell_act_e            act
);
    logic [NUM_SIDES-1:0] side_fire;

    assign side_fire = side_rise & side_gate;

    always_comb begin
        act = ACT_HOLD;
        unique case (mode_agree)
            1'b1: begin
                if (agree_a && agree_b) begin
                    act = ACT_SET;
                end else if (!agree_a && !agree_b) begin
                    act = ACT_CLEAR;
                end
            end
            1'b0: begin
                unique case (side_fire)
                    2'b11:   act = ACT_TOGGLE;
                    2'b01:   act = ACT_SET;
                    2'b10:   act = ACT_CLEAR;
                    default: act = ACT_HOLD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/trig_cell.sv
`timescale 1ns/1ps
module trig_cell
    import trig_cell_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_agree,
    input  logic set_trig,
    input  logic set_gate,
    input  logic clr_trig,
    input  logic clr_gate,
    input  logic agree_a,
    input  logic agree_b,
    input  logic force_set,
    input  logic force_clr,
    output logic q,
    output logic q_n
);
    logic [NUM_SIDES-1:0] side_trig;
    logic [NUM_SIDES-1:0] side_gate;
    logic [NUM_SIDES-1:0] side_rise;
    cell_act_e            act;
    cell_state_e          state_q;
    logic                 forcing;

    assign side_trig[SIDE_SET] = set_trig;
    assign side_trig[SIDE_CLR] = clr_trig;
    assign side_gate[SIDE_SET] = set_gate;
    assign side_gate[SIDE_CLR] = clr_gate;
    assign forcing = force_set | force_clr;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        trig_edge_detect #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_edge (
            .clk  (clk),
            .rst  (rst),
            .trig (side_trig[s]),
            .rise (side_rise[s])
        );
    end

    trig_action_decode u_decode (
        .mode_agree (mode_agree),
        .side_rise  (side_rise),
        .side_gate  (side_gate),
        .agree_a    (agree_a),
        .agree_b    (agree_b),
        .act        (act)
    );

    // State register: RESET, FORCE_LO/HI, then edge or agreement transitions
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
        end else if (force_clr) begin
            state_q <= ST_CLEAR;
        end else if (force_set) begin
            state_q <= ST_SET;
        end else begin
            unique case (state_q)
                ST_CLEAR: begin
                    if (act == ACT_SET || act == ACT_TOGGLE) begin
                        state_q <= ST_SET;
                    end
                end
                ST_SET: begin
                    if (act == ACT_CLEAR || act == ACT_TOGGLE) begin
                        state_q <= ST_CLEAR;
                    end
                end
            endcase
        end
    end

    // Output process: level forces override the stored bit at once
    always_comb begin
        if (force_clr) begin
            q = 1'b0;
        end else if (force_set) begin
            q = 1'b1;
        end else begin
            q = (state_q == ST_SET);
        end
        q_n = ~q;
    end

    assert_set_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (!forcing && !mode_agree && side_rise[SIDE_SET] && set_gate
         && !(side_rise[SIDE_CLR] && clr_gate)) |=> (state_q == ST_SET));

    assert_clr_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (!forcing && !mode_agree && side_rise[SIDE_CLR] && clr_gate
         && !(side_rise[SIDE_SET] && set_gate)) |=> (state_q == ST_CLEAR));

    assert_unqualified_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!forcing && !mode_agree && !(side_rise[SIDE_SET] && set_gate)
         && !(side_rise[SIDE_CLR] && clr_gate)) |=> $stable(state_q));

    assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (!forcing && !mode_agree && side_rise[SIDE_SET] && set_gate
         && side_rise[SIDE_CLR] && clr_gate) |=> (state_q != $past(state_q)));

    assert_force_load_R5: assert property (@(posedge clk) disable iff (rst)
        (force_set && !force_clr) |=> (state_q == ST_SET));

    assert_force_clr_dom_R6: assert property (@(posedge clk) disable iff (rst)
        force_clr |=> (state_q == ST_CLEAR));

    assert_agree_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (!forcing && mode_agree && (agree_a == agree_b))
        |=> ((state_q == ST_SET) == $past(agree_a)));

    assert_agree_skew_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!forcing && mode_agree && (agree_a != agree_b)) |=> $stable(state_q));

endmodule

// File: tb/trig_cell_tb.sv
`timescale 1ns/1ps
module trig_cell_tb;

    logic clk = 1'b0;
    logic rst;
    logic mode_agree, set_trig, set_gate, clr_trig, clr_gate;
    logic agree_a, agree_b, force_set, force_clr;
    logic q, q_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    trig_cell u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_agree (mode_agree),
        .set_trig   (set_trig),
        .set_gate   (set_gate),
        .clr_trig   (clr_trig),
        .clr_gate   (clr_gate),
        .agree_a    (agree_a),
        .agree_b    (agree_b),
        .force_set  (force_set),
        .force_clr  (force_clr),
        .q          (q),
        .q_n        (q_n)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic check_out(input logic exp, input string req, input string what);
        check(q, exp, req, what);
        check(q_n, ~exp, "R10", {what, " complement"});
    endtask

    task automatic quiet();
        mode_agree = 1'b0; set_trig = 1'b0; clr_trig = 1'b0;
        set_gate = 1'b0; clr_gate = 1'b0; force_set = 1'b0; force_clr = 1'b0;
    endtask

    // Load the stored bit through a force pulse, leaving all inputs quiet
    task automatic load(input logic v);
        @(negedge clk);
        force_set = v; force_clr = ~v;
        @(negedge clk);
        force_set = 1'b0; force_clr = 1'b0;
    endtask

    task automatic edge_case(input logic init, input logic se, input logic sg,
                             input logic ce, input logic cg);
        logic  exp;
        string tag;
        @(negedge clk);
        quiet();
        agree_a = 1'b1; agree_b = init;   // ignored in edge mode (R7)
        repeat (3) @(negedge clk);
        load(init);
        check_out(init, "R5", "loaded value");
        // N0: triggers and gates applied
        set_trig = se; clr_trig = ce; set_gate = sg; clr_gate = cg;
        if (se && sg && ce && cg)      begin exp = ~init; tag = "R4"; end
        else if (se && sg)             begin exp = 1'b1;  tag = ce ? "R3" : "R1"; end
        else if (ce && cg)             begin exp = 1'b0;  tag = se ? "R3" : "R2"; end
        else                           begin exp = init;  tag = "R3"; end
        @(negedge clk);
        @(negedge clk);
        check_out(init, "R8", "before edge acts");
        @(negedge clk);
        check_out(exp, tag, $sformatf("edge case se%0b sg%0b ce%0b cg%0b init%0b", se, sg, ce, cg, init));
        // Fall triggers, raise both gates with no edge
        set_trig = 1'b0; clr_trig = 1'b0; set_gate = 1'b1; clr_gate = 1'b1;
        repeat (4) @(negedge clk);
        check_out(exp, "R2", "gates high without edge");
    endtask

    initial begin
        #(200000 * 5.0);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        quiet();
        agree_a = 1'b0; agree_b = 1'b0;
        rst = 1'b1;
        set_trig = 1'b1; set_gate = 1'b1;
        repeat (4) @(negedge clk);
        check_out(1'b0, "R9", "reset state");
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_out(1'b0, "R9", "held trigger before edge");
        @(negedge clk);
        check_out(1'b1, "R9", "held trigger seen as edge after reset");
        set_trig = 1'b0;

        // Reset clears a set bit
        load(1'b1);
        rst = 1'b1;
        @(negedge clk);
        check_out(1'b0, "R9", "reset clears set bit");
        rst = 1'b0;

        // Exhaustive edge-mode sweep
        for (int i = 0; i < 32; i++) begin
            edge_case(i[4], i[3], i[2], i[1], i[0]);
        end

        // Agreement mode sweep
        for (int i = 0; i < 8; i++) begin
            logic init, a, b, exp;
            init = i[2]; a = i[1]; b = i[0];
            @(negedge clk);
            quiet();
            mode_agree = 1'b1;
            agree_a = ~init; agree_b = init;
            load(init);
            agree_a = a; agree_b = b;
            @(negedge clk);
            exp = (a && b) ? 1'b1 : ((!a && !b) ? 1'b0 : init);
            check_out(exp, "R7", $sformatf("agree a%0b b%0b init%0b", a, b, init));
        end

        // Agreement mode ignores trigger edges while inputs differ
        for (int i = 0; i < 2; i++) begin
            logic init;
            init = i[0];
            @(negedge clk);
            quiet();
            mode_agree = 1'b1; agree_a = 1'b1; agree_b = 1'b0;
            repeat (3) @(negedge clk);
            load(init);
            set_trig = ~init; set_gate = 1'b1; clr_trig = init; clr_gate = 1'b1;
            repeat (4) @(negedge clk);
            check_out(init, "R7", "edges ignored in agreement mode");
        end

        // Force sweep, with a qualified set edge during the force
        for (int i = 0; i < 8; i++) begin
            logic init, fs, fc, exp_now, exp_rel;
            init = i[2]; fs = i[1]; fc = i[0];
            @(negedge clk);
            quiet();
            agree_a = 1'b0; agree_b = 1'b0;
            repeat (3) @(negedge clk);
            load(init);
            force_set = fs; force_clr = fc;
            set_trig = 1'b1; set_gate = 1'b1;
            #1;
            exp_now = fc ? 1'b0 : (fs ? 1'b1 : init);
            check_out(exp_now, fc ? (fs ? "R6" : "R5") : "R5",
                      $sformatf("immediate force fs%0b fc%0b init%0b", fs, fc, init));
            repeat (3) @(negedge clk);
            force_set = 1'b0; force_clr = 1'b0;
            exp_rel = fc ? 1'b0 : 1'b1;
            #1;
            check_out(exp_rel, (fs || fc) ? "R5" : "R1",
                      $sformatf("after force fs%0b fc%0b init%0b", fs, fc, init));
            set_trig = 1'b0;
        end

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule